// File: doc/BRIEF.md
# Section BIP-8 Error Monitor

This block watches a byte-wide receive stream of STS-3c/STM-1 frames for section-layer bit errors. It runs on the bytes exactly as they arrive, still scrambled. It builds an even-parity BIP-8 over every byte of a frame: bit i of the code is the XOR of bit i of all bytes in that frame. It then checks that code against the B1 byte carried in the next frame. The upstream framer marks the first byte of each frame with `frame_sync` and qualifies every byte with `byte_en`. The block keeps its own byte position inside the frame, so it knows where the meaningful B1 sits.

A three-state controller decides when a check is valid:
- `ST_HUNT` is entered at reset or whenever `lof` is high.
- The transition "first sync" moves `ST_HUNT` to `ST_FIRST` on a frame start.
- The transition "second sync" moves `ST_FIRST` to `ST_TRACK` on the next frame start.
- The transition "framing lost" takes any state back to `ST_HUNT`.

A comparison happens only in `ST_TRACK`, because only there does a complete previous-frame parity exist.

Each mismatch sets the alarm `bip_err` and adds the number of differing bit positions to a 16-bit saturating error count. A host reads the count as two bytes through a snapshot latch, so increments that arrive during a read are never lost.

Top module: `sbip_monitor`

## Requirements
- R1: The parity of frame N is the bitwise XOR of every enabled byte from the `frame_sync` byte (index 0) up to the byte before the next `frame_sync`. It is compared with the byte at index FRAME_COLS of frame N+1 (row 2, column 1). A match leaves the count unchanged and drives `bip_err` low.
- R2: A compare whose two values differ drives `bip_err` high on the clock edge that accepts the B1 byte. `bip_err` then holds until the next compare or until `lof`.
- R3: The bytes at indices FRAME_COLS+1 and FRAME_COLS+2 (the B1 slots of the other constituent signals) start no compare. They change neither `bip_err` nor the count, though they still enter the parity.
- R4: Each compare adds to the error count the number of 1 bits in (computed parity XOR received B1), which is 0 to 8.
- R5: The error count saturates at 0xFFFF and never wraps.
- R6: A cycle with `rd_lo` high has two effects. `rd_data` on the next cycle equals bits 7:0 of the count held before that cycle. The live count restarts from that same cycle's increment, so no error is lost.
- R7: A cycle with `rd_hi` high (and `rd_lo` low) makes `rd_data` on the next cycle equal bits 15:8 of the count captured by the latest `rd_lo`.
- R8: No compare is made during the first frame after reset, or during the first frame after `lof`. `lof` clears `bip_err` on the next edge.
- R9: A cycle with `byte_en` low changes neither parity, position, count nor alarm.
- R10: After reset, `bip_err` is 0, `rd_data` is 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | Qualifies `rx_byte` and `frame_sync` |
| frame_sync | input | 1 | High on the first byte of a frame |
| rx_byte | input | 8 | Received (scrambled) byte |
| lof | input | 1 | Loss of framing from the framer |
| rd_lo | input | 1 | Read low byte, snapshot and restart count |
| rd_hi | input | 1 | Read high byte of the snapshot |
| rd_data | output | 8 | Read data, valid the cycle after a read strobe |
| bip_err | output | 1 | Section parity error alarm |

## Verification
The low-byte read and a B1 compare can land in the same cycle. In that case the count must be snapshotted and the fresh increment carried into the restarted counter. The bench provokes this by raising `rd_lo` together with a corrupted B1 byte. It then expects `rd_data` to show the count from before that frame's errors, and expects the following read to return exactly that frame's bit-error weight. Saturation and a compare also meet: thousands of all-bits-wrong frames are driven, and the bench expects the count to stick at 0xFFFF.

// File: rtl/sbip_pkg.sv
package sbip_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_TRACK = 2'd2
    } sbip_state_e;

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/sbip_frame_ctl.sv
module sbip_frame_ctl
    import sbip_pkg::*;
#(
    parameter int FRAME_BYTES = 2430,
    parameter int B1_IDX      = 270
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        frame_sync,
    input  logic        lof,
    output logic        cmp_en,
    output sbip_state_e state_o
);

    localparam int POS_W = $clog2(FRAME_BYTES + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES);
    localparam logic [POS_W-1:0] POS_B1   = POS_W'(B1_IDX);

    sbip_state_e       state, nxt;
    logic [POS_W-1:0]  pos;
    logic              sof;

    assign sof = byte_en && frame_sync;

    // position of the current byte within the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (sof) begin
            pos <= POS_W'(1);
        end else if (byte_en && (pos != POS_LAST)) begin
            pos <= pos + POS_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (lof) begin
            nxt = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT:  if (sof) nxt = ST_FIRST;
                ST_FIRST: if (sof) nxt = ST_TRACK;
                ST_TRACK: nxt = ST_TRACK;
                default:  nxt = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmp_en  = 1'b0;
        state_o = state;
        unique case (state)
            ST_HUNT:  cmp_en = 1'b0;
            ST_FIRST: cmp_en = 1'b0;
            ST_TRACK: cmp_en = byte_en && !frame_sync && !lof && (pos == POS_B1);
            default:  cmp_en = 1'b0;
        endcase
    end

    p_lof_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lof |=> (state == ST_HUNT));

    p_track_via_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK) && ($past(state) != ST_TRACK) |-> ($past(state) == ST_FIRST));

    p_idle_keeps_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(pos));

endmodule

// File: rtl/sbip_parity.sv
module sbip_parity (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic       frame_sync,
    input  logic [7:0] rx_byte,
    output logic [7:0] prev_par
);

    logic [7:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= 8'h00;
            prev_par <= 8'h00;
        end else if (byte_en) begin
            if (frame_sync) begin
                prev_par <= acc;
                acc      <= rx_byte;
            end else begin
                acc      <= acc ^ rx_byte;
            end
        end
    end

    p_prev_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_en && frame_sync) |=> $stable(prev_par));

endmodule

// File: rtl/sbip_err_count.sv
module sbip_err_count
    import sbip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_en,
    input  logic [7:0] mism,
    input  logic       lof,
    input  logic       rd_lo,
    input  logic       rd_hi,
    output logic [7:0] rd_data,
    output logic       bip_err
);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       snap_hi;
    logic [3:0]       inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_sat;

    assign inc     = cmp_en ? ones8(mism) : 4'd0;
    assign sum     = {1'b0, cnt} + {{(CNT_W-3){1'b0}}, inc};
    assign cnt_sat = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            snap_hi <= 8'h00;
            rd_data <= 8'h00;
        end else if (rd_lo) begin
            cnt     <= {{(CNT_W-4){1'b0}}, inc};
            snap_hi <= cnt[15:8];
            rd_data <= cnt[7:0];
        end else begin
            cnt <= cnt_sat;
            if (rd_hi) begin
                rd_data <= snap_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bip_err <= 1'b0;
        end else if (lof) begin
            bip_err <= 1'b0;
        end else if (cmp_en) begin
            bip_err <= |mism;
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo && (cnt == 16'hFFFF) |=> (cnt == 16'hFFFF));

    p_count_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> (cnt >= $past(cnt)));

    p_restart_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (cnt <= 16'd8));

    p_alarm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && (mism != 8'h00) && !lof |=> bip_err);

    p_lof_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lof |=> !bip_err);

endmodule

// File: rtl/sbip_monitor.sv
module sbip_monitor
    import sbip_pkg::*;
#(
    parameter int FRAME_COLS = 270,
    parameter int FRAME_ROWS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic       frame_sync,
    input  logic [7:0] rx_byte,
    input  logic       lof,
    input  logic       rd_lo,
    input  logic       rd_hi,
    output logic [7:0] rd_data,
    output logic       bip_err
);

    localparam int FRAME_BYTES = FRAME_COLS * FRAME_ROWS;
    localparam int B1_IDX      = FRAME_COLS;

    logic        cmp_en;
    sbip_state_e state;
    logic [7:0]  prev_par;
    logic [7:0]  mism;

    sbip_frame_ctl #(
        .FRAME_BYTES (FRAME_BYTES),
        .B1_IDX      (B1_IDX)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .frame_sync (frame_sync),
        .lof        (lof),
        .cmp_en     (cmp_en),
        .state_o    (state)
    );

    sbip_parity u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .frame_sync (frame_sync),
        .rx_byte    (rx_byte),
        .prev_par   (prev_par)
    );

    assign mism = rx_byte ^ prev_par;

    sbip_err_count u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_en  (cmp_en),
        .mism    (mism),
        .lof     (lof),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .rd_data (rd_data),
        .bip_err (bip_err)
    );

    p_cmp_needs_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (state == ST_TRACK) && !$isunknown(prev_par));

    p_quiet_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en && !lof |=> $stable(bip_err));

endmodule

// File: tb/sbip_monitor_bench.sv
module sbip_monitor_bench;

    localparam int CLK_PER = 10;
    localparam int FC      = 4;
    localparam int FR      = 2;
    localparam int FB      = FC * FR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_en = 1'b0;
    logic       frame_sync = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       lof = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic       bip_err;

    always #(CLK_PER/2) clk = ~clk;

    sbip_monitor #(.FRAME_COLS(FC), .FRAME_ROWS(FR)) u_sbip_monitor (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .frame_sync(frame_sync),
        .rx_byte(rx_byte), .lof(lof), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_data(rd_data), .bip_err(bip_err)
    );

    // scoreboard
    int         q_kind[$];
    logic [7:0] q_exp[$];
    string      q_tag[$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    // reference model state (from the requirements)
    int         m_st = 0;
    int         m_pos = 0;
    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_prev = 8'h00;
    int         m_cnt = 0;
    logic [7:0] m_hi = 8'h00;
    logic       m_err = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    bit         pe_v = 0;
    logic [7:0] pe_x;
    string      pe_t;
    bit         pr_v = 0;
    logic [7:0] pr_x;
    string      pr_t;

    function automatic int pop_cnt(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    function automatic logic [7:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    task automatic push(input int k, input logic [7:0] e, input string t);
        q_kind.push_back(k);
        q_exp.push_back(e);
        q_tag.push_back(t);
    endtask

    task automatic drive(input logic [7:0] d, input bit fs, input bit en,
                         input bit lf, input bit rl, input bit rh, input string t);
        bit cmp;
        int inc;
        @(posedge clk);
        #1;
        if (pe_v) push(0, pe_x, pe_t);
        if (pr_v) push(1, pr_x, pr_t);
        pe_v = 0;
        pr_v = 0;
        rx_byte = d; frame_sync = fs; byte_en = en; lof = lf; rd_lo = rl; rd_hi = rh;
        cmp = (m_st == 2) && en && !fs && !lf && (m_pos == FC);
        inc = cmp ? pop_cnt(d ^ m_prev) : 0;
        if (rl) begin
            pr_v = 1; pr_x = m_cnt[7:0]; pr_t = t;
            m_hi = m_cnt[15:8];
            m_cnt = inc;
        end else begin
            m_cnt = (m_cnt + inc > 65535) ? 65535 : m_cnt + inc;
            if (rh) begin
                pr_v = 1; pr_x = m_hi; pr_t = t;
            end
        end
        if (lf) m_err = 1'b0;
        else if (cmp) m_err = ((d ^ m_prev) != 8'h00);
        if (en) begin
            pe_v = 1; pe_x = {7'b0, m_err}; pe_t = t;
        end
        if (en && fs) begin
            m_prev = m_acc; m_acc = d; m_pos = 1;
        end else if (en) begin
            m_acc = m_acc ^ d;
            if (m_pos < FB) m_pos++;
        end
        if (lf) m_st = 0;
        else if (en && fs) m_st = (m_st == 0) ? 1 : 2;
    endtask

    task automatic idle(input bit lf, input bit rl, input bit rh, input string t);
        drive(next_rand(), 1'b0, 1'b0, lf, rl, rh, t);
    endtask

    task automatic send_frame(input logic [7:0] mask, input bit gap,
                              input bit rd_at_b1, input string t);
        for (int i = 0; i < FB; i++) begin
            logic [7:0] d;
            string tg;
            if (gap && i == 2) idle(1'b0, 1'b0, 1'b0, "R9");
            d = next_rand();
            tg = "R1";
            if (i == FC) begin
                d = m_prev ^ mask;
                tg = t;
            end else if (i == FC + 1 || i == FC + 2) begin
                tg = "R3";
            end
            drive(d, i == 0, 1'b1, 1'b0, rd_at_b1 && (i == FC), 1'b0, tg);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int         k;
            logic [7:0] e;
            logic [7:0] a;
            string      t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = (k == 0) ? {7'b0, bip_err} : rd_data;
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s %s actual=%h expected=%h at %0t",
                         t, (k == 0) ? "bip_err" : "rd_data", a, e, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push(0, 8'h00, "R10");
        push(1, 8'h00, "R10");
        idle(1'b0, 1'b1, 1'b0, "R10");        // count after reset reads 0
        idle(1'b0, 1'b0, 1'b0, "R10");

        send_frame(8'h3C, 0, 0, "R8");        // first frame: no compare
        send_frame(8'h00, 0, 0, "R1");        // good parity
        send_frame(8'h01, 0, 0, "R2");        // one bit wrong
        send_frame(8'hA5, 1, 0, "R4");        // four bits, with an idle gap
        send_frame(8'h00, 0, 0, "R1");
        idle(1'b0, 1'b1, 1'b0, "R6");         // reads 5
        idle(1'b0, 1'b0, 1'b1, "R7");         // reads 0
        send_frame(8'h0F, 0, 1, "R6");        // read coincides with compare
        idle(1'b0, 1'b1, 1'b0, "R6");         // reads 4 carried in
        send_frame(8'h80, 0, 0, "R2");
        idle(1'b1, 1'b0, 1'b0, "R8");         // loss of framing
        send_frame(8'hFF, 0, 0, "R8");        // first frame again
        send_frame(8'h00, 0, 0, "R1");
        idle(1'b0, 1'b1, 1'b0, "R8");         // reads 1 (from 0x80 frame)
        for (int f = 0; f < 8200; f++) send_frame(8'hFF, 0, 0, "R5");
        idle(1'b0, 1'b1, 1'b0, "R5");
        idle(1'b0, 1'b0, 1'b1, "R5");
        send_frame(8'h00, 0, 0, "R1");
        idle(1'b0, 1'b1, 1'b0, "R6");
        repeat (3) idle(1'b0, 1'b0, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule